// File: doc/BRIEF.md
# Character blink phase generator

This block decides, field by field, whether blinking items on the display are currently shown or hidden. It counts vertical sync pulses into a wrapping field counter and compares the count against an on-phase length derived from a period setting and a duty setting. The single visible flag it produces is shared by every text character and by the sprite. The pixel pipeline ANDs this flag with an item's own blink bit, so items without a blink bit are never affected.

The settings arrive in a 16-bit control word with a load strobe. Only one command code loads the block. That same word also carries a two-bit trimming-format field, which is latched and brought out unchanged for the downstream trimming logic. Loading a new setting restarts the field count, so the next field always begins with a shown phase.

Top module: `blink_phase_gen`

## Requirements
- R1: A word is accepted on `cmd_strobe` only when bits[15:12] = 4'b0101 and bits[11:10] = 2'b01. Bits[7:6] then give the period code, bits[5:4] the duty code and bits[9:8] the trimming format. The trimming format appears on `trim_fmt` one clock after the strobe.
- R2: A strobed word with any other value in bits[15:10] leaves the settings, `trim_fmt`, the field count and `blink_visible` unchanged.
- R3: Period codes 0, 1, 2 and 3 select 16, 32, 48 and 64 fields. The field count wraps to zero after the last field of the period.
- R4: Duty code 0 keeps `blink_visible` high in every field.
- R5: Duty code 1 makes `blink_visible` high for the first half of the period and low for the second half.
- R6: Duty code 2 makes `blink_visible` high for the first quarter of the period and low for the rest.
- R7: Duty code 3 makes `blink_visible` high for the first three quarters of the period and low for the last quarter.
- R8: An accepted word clears the field count in the clock after the strobe, so `blink_visible` is high. An accepted word takes precedence over a vsync edge in the same clock.
- R9: After reset the period code is 0 (16 fields), the duty code is 0 (always visible), `trim_fmt` is 0 and the field count is 0.
- R10: The field count advances by one for each rising edge of `vsync_in`, however many clocks the pulse stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_in | input | 1 | Vertical sync, active high, synchronous to clk |
| cmd_word | input | 16 | Control command word |
| cmd_strobe | input | 1 | Qualifies `cmd_word` for one clock |
| blink_visible | output | 1 | High while blinking items are shown |
| trim_fmt | output | 2 | Latched trimming-format field |

## Verification
The assertions assume that `vsync_in` and `cmd_word` are already synchronous to `clk` and that `cmd_word` is stable whenever `cmd_strobe` is high. The stimulus changes every input only on the falling clock edge. It mixes accepted and rejected words, and it drives vsync pulses that last one to three clocks with gaps between them. Directed sequences place the field count just before and just after each on/off boundary and the wrap point. A held vsync pulse is included to show that only its rising edge advances the count.

// File: rtl/blink_pkg.sv
// Shared types and command decode constants for the blink phase generator.
package blink_pkg;

    localparam logic [3:0] CMD_GROUP = 4'b0101;
    localparam logic [1:0] CMD_SUB   = 2'b01;

    typedef enum logic [1:0] {
        DUTY_SOLID   = 2'd0,
        DUTY_HALF    = 2'd1,
        DUTY_QUARTER = 2'd2,
        DUTY_THREEQ  = 2'd3
    } duty_e;

    typedef struct packed {
        logic [1:0] trim_fmt;
        logic [1:0] period_sel;
        duty_e      duty_sel;
    } blink_cfg_t;

endpackage

// File: rtl/blink_cmd_latch.sv
// Decodes the control word and holds the blink settings.
// Assumes cmd_word is stable while cmd_strobe is high.
module blink_cmd_latch
    import blink_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cmd_word,
    input  logic        cmd_strobe,
    output blink_cfg_t  cfg,
    output logic        cfg_load
);

    // Match the command code and sub-code.
    always_comb begin
        cfg_load = cmd_strobe && (cmd_word[15:12] == CMD_GROUP)
                              && (cmd_word[11:10] == CMD_SUB);
    end

    // Hold the settings; reset gives period 16 and always on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{trim_fmt: 2'b00, period_sel: 2'b00, duty_sel: DUTY_SOLID};
        end else if (cfg_load) begin
            cfg.trim_fmt   <= cmd_word[9:8];
            cfg.period_sel <= cmd_word[7:6];
            cfg.duty_sel   <= duty_e'(cmd_word[5:4]);
        end
    end

    assert_reject_other_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && (cmd_word[15:10] != {CMD_GROUP, CMD_SUB})) |=> $stable(cfg));

    assert_fields_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (cfg.trim_fmt == $past(cmd_word[9:8])) &&
                     (cfg.period_sel == $past(cmd_word[7:6])));

endmodule

// File: rtl/blink_vsync_edge.sv
// Turns the vertical sync level into a single-clock advance pulse on its
// rising edge. Assumes vsync_in is already synchronous to clk.
module blink_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    output logic advance
);

    logic vsync_q;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync_in;
    end

    // Rising edge detect.
    always_comb advance = vsync_in && !vsync_q;

    assert_single_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> !advance);

endmodule

// File: rtl/blink_field_counter.sv
// Counts vertical fields modulo the selected period. A load clears the
// count and takes precedence over an advance in the same clock.
module blink_field_counter #(
    parameter int BASE_FIELDS = 16,
    parameter int CNT_W       = $clog2(4 * BASE_FIELDS),
    parameter int LEN_W       = $clog2(4 * BASE_FIELDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    input  logic [1:0]       period_sel,
    output logic [CNT_W-1:0] field_cnt,
    output logic [LEN_W-1:0] period_len
);

    logic [LEN_W-1:0] mult;
    logic             at_last;

    // Period length is a whole multiple of the base field count.
    always_comb begin
        mult       = LEN_W'(period_sel) + LEN_W'(1);
        period_len = LEN_W'(BASE_FIELDS) * mult;
        at_last    = ({1'b0, field_cnt} == period_len - LEN_W'(1));
    end

    // Advance on each vsync edge, wrap at the period, clear on load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) field_cnt <= '0;
        else if (advance)    field_cnt <= at_last ? '0 : field_cnt + CNT_W'(1);
    end

    assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, field_cnt} < period_len));

    assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (field_cnt == '0));

    assert_hold_without_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(field_cnt));

endmodule

// File: rtl/blink_phase_compare.sv
// Derives the on-phase length from the duty code and compares the field
// count against it. Every period starts with the on phase.
module blink_phase_compare
    import blink_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  duty_e            duty_sel,
    input  logic [CNT_W-1:0] field_cnt,
    input  logic [LEN_W-1:0] period_len,
    output logic             visible
);

    logic [LEN_W-1:0] on_len;

    // On length: full, half, quarter or three quarters of the period.
    always_comb begin
        unique case (duty_sel)
            DUTY_SOLID:   on_len = period_len;
            DUTY_HALF:    on_len = period_len >> 1;
            DUTY_QUARTER: on_len = period_len >> 2;
            DUTY_THREEQ:  on_len = period_len - (period_len >> 2);
            default:      on_len = period_len;
        endcase
        visible = ({1'b0, field_cnt} < on_len);
    end

    assert_solid_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel == DUTY_SOLID) |-> visible);

    assert_period_starts_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_cnt == '0) |-> visible);

endmodule

// File: rtl/blink_phase_gen.sv
// Top level: blink visibility shared by characters and sprite.
// Assumes all inputs are synchronous to clk.
module blink_phase_gen
    import blink_pkg::*;
#(
    parameter int BASE_FIELDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vsync_in,
    input  logic [15:0] cmd_word,
    input  logic        cmd_strobe,
    output logic        blink_visible,
    output logic [1:0]  trim_fmt
);

    localparam int CNT_W = $clog2(4 * BASE_FIELDS);
    localparam int LEN_W = $clog2(4 * BASE_FIELDS + 1);

    blink_cfg_t       cfg;
    logic             cfg_load;
    logic             advance;
    logic [CNT_W-1:0] field_cnt;
    logic [LEN_W-1:0] period_len;

    blink_cmd_latch u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word),
        .cmd_strobe(cmd_strobe), .cfg(cfg), .cfg_load(cfg_load)
    );

    blink_vsync_edge u_edge (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .advance(advance)
    );

    blink_field_counter #(
        .BASE_FIELDS(BASE_FIELDS), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .advance(advance), .clear(cfg_load),
        .period_sel(cfg.period_sel), .field_cnt(field_cnt),
        .period_len(period_len)
    );

    blink_phase_compare #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .duty_sel(cfg.duty_sel),
        .field_cnt(field_cnt), .period_len(period_len),
        .visible(blink_visible)
    );

    // Trimming format passes straight through from the latch.
    always_comb trim_fmt = cfg.trim_fmt;

endmodule

// File: tb/test_blink_phase_gen.sv
module test_blink_phase_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync_in = 1'b0;
    logic [15:0] cmd_word = 16'h0;
    logic        cmd_strobe = 1'b0;
    logic        blink_visible;
    logic [1:0]  trim_fmt;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_period = 16;
    int m_duty = 0;
    int m_cnt = 0;
    int m_fm = 0;
    bit m_prev = 1'b0;

    blink_phase_gen i_blink_phase_gen (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .cmd_word(cmd_word),
        .cmd_strobe(cmd_strobe), .blink_visible(blink_visible), .trim_fmt(trim_fmt)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int on_len(input int p, input int d);
        case (d)
            0: return p;
            1: return p / 2;
            2: return p / 4;
            default: return (p * 3) / 4;
        endcase
    endfunction

    // Reference model, updated on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_period = 16; m_duty = 0; m_cnt = 0; m_fm = 0; m_prev = 1'b0;
        end else begin
            bit edge_seen;
            edge_seen = vsync_in && !m_prev;
            m_prev = vsync_in;
            if (cmd_strobe && cmd_word[15:10] == 6'b010101) begin
                m_fm = int'(cmd_word[9:8]);
                m_period = 16 * (int'(cmd_word[7:6]) + 1);
                m_duty = int'(cmd_word[5:4]);
                m_cnt = 0;
            end else if (edge_seen) begin
                m_cnt = (m_cnt + 1) % m_period;
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            case (m_duty)
                0: tag = "R4";
                1: tag = "R5";
                2: tag = "R6";
                default: tag = "R7";
            endcase
            chk(tag, int'(blink_visible), int'(m_cnt < on_len(m_period, m_duty)));
            chk("R1", int'(trim_fmt), m_fm);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [15:0] mk(input int fm, input int bt, input int bd, input int lo);
        return {4'b0101, 2'b01, 2'(fm), 2'(bt), 2'(bd), 4'(lo)};
    endfunction

    task automatic send(input logic [15:0] w);
        @(negedge clk); cmd_word = w; cmd_strobe = 1'b1;
        @(negedge clk); cmd_strobe = 1'b0;
    endtask

    task automatic pulse(input int width);
        @(negedge clk); vsync_in = 1'b1;
        for (int k = 1; k < width; k++) @(negedge clk);
        @(negedge clk); vsync_in = 1'b0;
        @(negedge clk);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 visible", int'(blink_visible), 1);
        chk("R9 trim", int'(trim_fmt), 0);
        repeat (20) pulse(1);
        chk("R9 always on after 20 fields", int'(blink_visible), 1);

        // R1 and R3 and R5: period 16, half duty
        send(mk(2, 0, 1, 5));
        chk("R1 trim", int'(trim_fmt), 2);
        chk("R8 fresh on", int'(blink_visible), 1);
        repeat (7) pulse(1);
        chk("R5 field 7 on", int'(blink_visible), 1);
        pulse(1);
        chk("R5 field 8 off", int'(blink_visible), 0);
        // R2: rejected words change nothing
        send({4'b0101, 2'b10, 2'b01, 2'b00, 2'b00, 4'h0});
        send({4'b0110, 2'b01, 2'b11, 2'b00, 2'b00, 4'h0});
        chk("R2 visible held", int'(blink_visible), 0);
        chk("R2 trim held", int'(trim_fmt), 2);
        repeat (8) pulse(1);
        chk("R3 wrap at 16", int'(blink_visible), 1);

        // R10: held pulses count once each
        repeat (4) pulse(2);
        chk("R10 held pulse counted once", int'(blink_visible), 1);
        repeat (4) pulse(3);
        chk("R10 field 8 off", int'(blink_visible), 0);

        // R8: reload restarts the on phase
        send(mk(2, 0, 1, 0));
        chk("R8 reload on", int'(blink_visible), 1);

        // R6: period 32, quarter duty
        send(mk(1, 1, 2, 0));
        repeat (7) pulse(1);
        chk("R6 field 7 on", int'(blink_visible), 1);
        pulse(1);
        chk("R6 field 8 off", int'(blink_visible), 0);
        repeat (24) pulse(1);
        chk("R3 wrap at 32", int'(blink_visible), 1);

        // R7: period 64, three-quarter duty
        send(mk(3, 3, 3, 0));
        repeat (47) pulse(1);
        chk("R7 field 47 on", int'(blink_visible), 1);
        pulse(1);
        chk("R7 field 48 off", int'(blink_visible), 0);
        repeat (15) pulse(1);
        chk("R7 field 63 off", int'(blink_visible), 0);
        pulse(1);
        chk("R3 wrap at 64", int'(blink_visible), 1);

        // R3: period 48, half duty
        send(mk(0, 2, 1, 0));
        repeat (24) pulse(1);
        chk("R3 period 48 field 24 off", int'(blink_visible), 0);
        repeat (24) pulse(1);
        chk("R3 wrap at 48", int'(blink_visible), 1);

        // R8: load and vsync edge in the same clock
        @(negedge clk); vsync_in = 1'b1; cmd_word = mk(0, 0, 2, 0); cmd_strobe = 1'b1;
        @(negedge clk); cmd_strobe = 1'b0; vsync_in = 1'b0;
        repeat (3) pulse(1);
        chk("R8 load wins over edge", int'(blink_visible), 1);
        pulse(1);
        chk("R8 field 4 off", int'(blink_visible), 0);

        // Mixed pseudo-random traffic checked by the model every clock
        for (int i = 0; i < 3000; i++) begin
            lfsr = nxt(lfsr);
            case (lfsr[2:0])
                3'd0: send(mk(int'(lfsr[4:3]), int'(lfsr[6:5]), int'(lfsr[8:7]), int'(lfsr[12:9])));
                3'd1: send({lfsr[15:10] == 6'b010101 ? 6'b010100 : lfsr[15:10], lfsr[9:0]});
                default: pulse(int'(lfsr[4:3] % 3) + 1);
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule